// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block holds the coherence state of a small group of cache lines that belong to one cache on a shared snooping bus. It runs a write-invalidate protocol with four states per line. Toward the processor it answers read and write requests. An access that the local copy can serve completes in the same cycle as a hit. Any other access becomes a bus transaction: a read, a read-with-intent-to-modify, or an invalidate. The controller holds the processor until that transaction has been granted and its response cycle has gone by.

Toward the bus it watches the transactions that other caches issue. One cycle after each snooped address it answers with a shared flag and a copyback flag, and it moves the snooped line to its new state. Tag lookup, data storage, arbitration and memory are outside the block. A line is named by its index. The bus grant and the shared response of the other caches arrive as plain inputs.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, and cpu_ack, cpu_hit, bus_req, snp_shared and snp_copyback are low.
- R2: A read of a line in Shared, Exclusive or Modified raises cpu_ack and cpu_hit in the same cycle, issues nothing on the bus and leaves the line state unchanged.
- R3: A read of an Invalid line raises bus_req from the next cycle with bus_cmd=0 (read) and bus_idx set to the line. The cycle after bus_gnt is the response cycle: cpu_ack rises with cpu_hit low, and the line fills to Shared if bus_shared_in is high in that cycle and to Exclusive otherwise.
- R4: A write to an Invalid line issues bus_cmd=1 (read-with-intent-to-modify) with the same timing as R3, and the line fills to Modified.
- R5: A write to a Shared line issues bus_cmd=2 (invalidate) with the same timing as R3, and the line then becomes Modified.
- R6: A write to an Exclusive line completes as a hit in the same cycle and silently moves the line to Modified. A write to a Modified line completes as a hit and changes nothing.
- R7: A snooped read (snp_cmd=0) that finds the line Modified raises snp_shared and snp_copyback in the next cycle and moves the line to Shared. A snooped read that finds it Exclusive or Shared raises only snp_shared and leaves the line Shared.
- R8: A snooped read-with-intent-to-modify (1), invalidate (2) or write (3) moves a valid line to Invalid. Only code 1 that finds the line Modified raises snp_copyback in the next cycle. A snoop that finds the line Invalid raises no response.
- R9: Snoop responses appear exactly one cycle after snp_valid and last one cycle. snp_shared is never raised for codes 1 to 3.
- R10: While a transaction is pending, the processor gets no cpu_ack, and bus_req and bus_idx hold until bus_gnt. bus_cmd follows the current line state, so a pending invalidate turns into a read-with-intent-to-modify if a snoop invalidates the line before the grant.
- R11: A snoop in the same cycle as a local hit or a response cycle acts on the line state that the local action leaves, both for its response and for the next state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor request, held until cpu_ack |
| cpu_we | input | 1 | Request is a write |
| cpu_idx | input | IW | Line index of the request |
| cpu_ack | output | 1 | Request completes this cycle |
| cpu_hit | output | 1 | Request completes locally without a bus transaction |
| bus_req | output | 1 | Transaction waiting for grant |
| bus_cmd | output | 2 | Transaction code: 0 read, 1 read-with-intent-to-modify, 2 invalidate |
| bus_idx | output | IW | Line index of the transaction |
| bus_gnt | input | 1 | Grant; the transaction is on the bus this cycle |
| bus_shared_in | input | 1 | Another cache holds the line (response cycle) |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped code: 0 read, 1 read-with-intent-to-modify, 2 invalidate, 3 write |
| snp_idx | input | IW | Line index of the snooped transaction |
| snp_shared | output | 1 | This cache holds the snooped line (one cycle later) |
| snp_copyback | output | 1 | This cache supplies the modified line (one cycle later) |

## Verification
The hardest case to reach is a snoop that lands on the line of this cache's own pending request while that request waits for the grant. A Shared-line write must lose its line there and switch from invalidate to read-with-intent-to-modify. The bench delays the grant by a chosen number of cycles and injects a snoop at a chosen iteration of the access. With the same mechanism it places snoops on the hit cycle and on the response cycle, to cover the ordering in R11. A reference model that runs cycle by cycle judges every output in every cycle, in both the directed sequence and a long random mix.

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl #(
  parameter int LINES = 4,
  parameter int IW    = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [IW-1:0] cpu_idx,
  output logic          cpu_ack,
  output logic          cpu_hit,
  output logic          bus_req,
  output logic [1:0]    bus_cmd,
  output logic [IW-1:0] bus_idx,
  input  logic          bus_gnt,
  input  logic          bus_shared_in,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [IW-1:0] snp_idx,
  output logic          snp_shared,
  output logic          snp_copyback
);

  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3;
  localparam logic [1:0] CMD_RD = 2'd0, CMD_RDX = 2'd1, CMD_INV = 2'd2;

  typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_RESP} phase_t;

  phase_t                    ph_q;
  logic [LINES-1:0][1:0]     line_q, line_d;
  logic [IW-1:0]             pend_idx_q;
  logic                      pend_we_q;
  logic [1:0]                cmd_q;
  logic [1:0]                cur_st, pend_st, fill_st, snp_st;
  logic                      sh_d, cb_d;

  assign cur_st  = line_q[cpu_idx];
  assign pend_st = line_q[pend_idx_q];

  assign cpu_hit = cpu_req && (ph_q == PH_IDLE) && (cpu_we ? cur_st[1] : (cur_st != ST_I));
  assign cpu_ack = cpu_hit || (ph_q == PH_RESP);

  assign bus_req = (ph_q == PH_WAIT);
  assign bus_idx = pend_idx_q;
  assign bus_cmd = !pend_we_q ? CMD_RD : ((pend_st == ST_S) ? CMD_INV : CMD_RDX);

  assign fill_st = (cmd_q == CMD_RD) ? (bus_shared_in ? ST_S : ST_E) : ST_M;

  always_comb begin
    line_d = line_q;
    if (cpu_hit && cpu_we) line_d[cpu_idx] = ST_M;
    if (ph_q == PH_RESP)   line_d[pend_idx_q] = fill_st;
    snp_st = line_d[snp_idx];
    sh_d = 1'b0;
    cb_d = 1'b0;
    if (snp_valid) begin
      case (snp_cmd)
        CMD_RD: begin
          sh_d = (snp_st != ST_I);
          cb_d = (snp_st == ST_M);
          if (snp_st != ST_I) line_d[snp_idx] = ST_S;
        end
        CMD_RDX: begin
          cb_d = (snp_st == ST_M);
          line_d[snp_idx] = ST_I;
        end
        default: line_d[snp_idx] = ST_I;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q         <= PH_IDLE;
      line_q       <= '0;
      pend_idx_q   <= '0;
      pend_we_q    <= 1'b0;
      cmd_q        <= CMD_RD;
      snp_shared   <= 1'b0;
      snp_copyback <= 1'b0;
    end else begin
      line_q       <= line_d;
      snp_shared   <= sh_d;
      snp_copyback <= cb_d;
      case (ph_q)
        PH_IDLE: if (cpu_req && !cpu_hit) begin
          ph_q       <= PH_WAIT;
          pend_idx_q <= cpu_idx;
          pend_we_q  <= cpu_we;
        end
        PH_WAIT: if (bus_gnt) begin
          ph_q  <= PH_RESP;
          cmd_q <= bus_cmd;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk #(
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req,
  input logic          cpu_ack,
  input logic          cpu_hit,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic [IW-1:0] bus_idx,
  input logic          snp_valid,
  input logic [1:0]    snp_cmd,
  input logic          snp_shared,
  input logic          snp_copyback
);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_idx));

  // R10
  no_ack_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !cpu_ack);

  // R3
  resp_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt |=> cpu_ack && !cpu_hit && !bus_req);

  // R2
  hit_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hit |-> cpu_ack && cpu_req);

  // R9
  shared_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_shared |-> $past(snp_valid) && ($past(snp_cmd) == 2'd0));

  // R8
  copyback_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_copyback |-> $past(snp_valid) && ($past(snp_cmd) == 2'd0 || $past(snp_cmd) == 2'd1));

  // R7
  copyback_read_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_copyback && ($past(snp_cmd) == 2'd0) |-> snp_shared);

endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_ack(cpu_ack), .cpu_hit(cpu_hit),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_idx(bus_idx),
  .snp_valid(snp_valid), .snp_cmd(snp_cmd),
  .snp_shared(snp_shared), .snp_copyback(snp_copyback)
);

// File: tb/mesi_line_ctrl_test.sv
module mesi_line_ctrl_test;
  localparam int PERIOD = 10;
  localparam int LINES  = 4;
  localparam int IW     = 2;
  localparam int I = 0, S = 1, E = 2, M = 3;
  localparam int RD = 0, RDX = 1, INV = 2, WR = 3;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [IW-1:0] cpu_idx = '0, snp_idx = '0, bus_idx;
  logic cpu_ack, cpu_hit, bus_req, snp_shared, snp_copyback;
  logic [1:0] bus_cmd, snp_cmd = '0;
  logic bus_gnt = 0, bus_shared_in = 0, snp_valid = 0;

  always #(PERIOD/2) clk = ~clk;

  mesi_line_ctrl #(.LINES(LINES)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_idx(cpu_idx),
    .cpu_ack(cpu_ack), .cpu_hit(cpu_hit), .bus_req(bus_req), .bus_cmd(bus_cmd),
    .bus_idx(bus_idx), .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_idx(snp_idx),
    .snp_shared(snp_shared), .snp_copyback(snp_copyback));

  int vectors = 0, miscompares = 0;
  string tag = "R1";

  int ln[LINES];
  int m_ph = 0, m_pidx = 0, m_pcmd = 0;
  bit m_pwe = 0, m_sh = 0, m_cb = 0;
  bit e_hit, e_ack, e_breq;
  int e_cmd;

  task automatic cmp(input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    int eff[LINES];
    int v;
    bit sh, cb;
    #1;
    if (m_ph == 0 && cpu_req) begin
      if (cpu_we) e_hit = (ln[cpu_idx] == E || ln[cpu_idx] == M);
      else        e_hit = (ln[cpu_idx] != I);
    end else e_hit = 0;
    e_ack  = e_hit || (m_ph == 2);
    e_breq = (m_ph == 1);
    if (!m_pwe) e_cmd = RD;
    else if (ln[m_pidx] == S) e_cmd = INV;
    else e_cmd = RDX;
    cmp("cpu_ack", cpu_ack, e_ack);
    cmp("cpu_hit", cpu_hit, e_hit);
    cmp("bus_req", bus_req, e_breq);
    if (e_breq) begin
      cmp("bus_cmd", bus_cmd, e_cmd);
      cmp("bus_idx", bus_idx, m_pidx);
    end
    cmp("snp_shared", snp_shared, m_sh);
    cmp("snp_copyback", snp_copyback, m_cb);
    @(posedge clk);
    eff = ln;
    if (e_hit && cpu_we) eff[cpu_idx] = M;
    if (m_ph == 2) eff[m_pidx] = (m_pcmd == RD) ? (bus_shared_in ? S : E) : M;
    sh = 0; cb = 0;
    if (snp_valid) begin
      v = eff[snp_idx];
      if (snp_cmd == RD) begin
        sh = (v != I); cb = (v == M);
        if (v != I) eff[snp_idx] = S;
      end else begin
        cb = (snp_cmd == RDX) && (v == M);
        eff[snp_idx] = I;
      end
    end
    if (m_ph == 0 && cpu_req && !e_hit) begin
      m_ph = 1; m_pidx = cpu_idx; m_pwe = cpu_we;
    end else if (m_ph == 1 && bus_gnt) begin
      m_ph = 2; m_pcmd = e_cmd;
    end else if (m_ph == 2) m_ph = 0;
    ln = eff; m_sh = sh; m_cb = cb;
    @(negedge clk);
  endtask

  task automatic access(input bit we, input int idx, input int dly, input bit shr,
                        input int inj_at, input int inj_cmd, input int inj_idx);
    int w = 0;
    bit done = 0;
    cpu_req = 1; cpu_we = we; cpu_idx = IW'(idx);
    for (int it = 0; !done && it < 60; it++) begin
      bus_gnt       = (m_ph == 1) && (w >= dly) && (it != inj_at);
      bus_shared_in = (m_ph == 2) ? shr : 1'b0;
      snp_valid     = (it == inj_at);
      snp_cmd       = 2'(inj_cmd);
      snp_idx       = IW'(inj_idx);
      if (m_ph == 1) w++;
      tick();
      done = e_ack;
      if (it == 59) cmp("access hung", 0, 1);
    end
    cpu_req = 0; bus_gnt = 0; bus_shared_in = 0; snp_valid = 0;
  endtask

  task automatic snoop(input int cmd, input int idx);
    snp_valid = 1; snp_cmd = 2'(cmd); snp_idx = IW'(idx);
    tick();
    snp_valid = 0;
    tick();
  endtask

  initial begin
    for (int k = 0; k < LINES; k++) ln[k] = I;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1"; tick(); tick();
    tag = "R3"; access(0, 0, 0, 0, -1, 0, 0); access(0, 1, 2, 1, -1, 0, 0);
    tag = "R2"; access(0, 0, 0, 0, -1, 0, 0); access(0, 1, 0, 0, -1, 0, 0);
    tag = "R6"; access(1, 0, 0, 0, -1, 0, 0); access(1, 0, 0, 0, -1, 0, 0);
    tag = "R5"; access(1, 1, 1, 0, -1, 0, 0);
    tag = "R4"; access(1, 2, 1, 1, -1, 0, 0);
    tag = "R7"; snoop(RD, 0); access(0, 0, 0, 0, -1, 0, 0);
    access(0, 3, 0, 0, -1, 0, 0); snoop(RD, 3); snoop(RD, 3);
    tag = "R8"; snoop(RDX, 2); snoop(INV, 1); snoop(WR, 0); snoop(RD, 0); snoop(RDX, 3);
    tag = "R9"; access(1, 2, 0, 0, -1, 0, 0); snoop(INV, 2); snoop(RDX, 2);
    tag = "R10"; access(0, 1, 0, 1, -1, 0, 0); access(1, 1, 3, 0, 2, INV, 1);
    access(0, 2, 4, 0, 3, RD, 1);
    tag = "R11"; access(0, 3, 0, 0, -1, 0, 0); access(1, 3, 0, 0, 0, RD, 3);
    access(0, 0, 0, 0, 2, RDX, 0); access(1, 2, 0, 0, 2, RD, 2);
    tag = "R11 random";
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 3) == 0)
        snoop(int'($urandom_range(0, 3)), int'($urandom_range(0, LINES-1)));
      else
        access(1'($urandom_range(0, 1)), int'($urandom_range(0, LINES-1)),
               int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
               ($urandom_range(0, 1) == 1) ? int'($urandom_range(0, 5)) : -1,
               int'($urandom_range(0, 3)), int'($urandom_range(0, LINES-1)));
    end
    tick(); tick();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog expired, actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule